// File: doc/BRIEF.md
# Immediate-Amount Barrel Shifter with Carry Out

This block is the operand-two shifter of a 32-bit integer datapath. One operand goes in, together with a 2-bit shift kind, a 5-bit immediate amount, the current carry flag and a flag-update enable. The block returns the shifted value and the carry that the flag logic should store. It is purely combinational, so both outputs follow the inputs in the same cycle.

An amount field of zero is not always a plain "no shift". For the two right shifts it stands for a shift by the full word width. For rotate it selects a one-bit rotate through the carry flag. Each of these cases has its own carry rule. When the flag-update enable is low, the carry output repeats the incoming carry, whatever the shift does. The ALU, the flag register and register-specified amounts are outside the block.

Top module: `imm_barrel_shift`

## Requirements
- R1: With kind 0 (left logical) and a nonzero amount n, the result is the operand shifted left by n with zeros in the vacated low bits, and the new carry is operand bit 32-n.
- R2: With kind 0 and amount 0, the result equals the operand and the new carry equals the incoming carry.
- R3: With kind 1 (right logical) and a nonzero amount n, the result is the operand shifted right by n with zeros in the vacated high bits, and the new carry is operand bit n-1.
- R4: With kind 1 and amount 0, the result is all zeros and the new carry is operand bit 31.
- R5: With kind 2 (right arithmetic) and a nonzero amount n, the result is the operand shifted right by n with copies of bit 31 in the vacated bits, and the new carry is operand bit n-1.
- R6: With kind 2 and amount 0, every result bit equals operand bit 31, and so does the new carry.
- R7: With kind 3 (rotate right) and a nonzero amount n, the bits that leave at the low end re-enter at the high end, and the new carry equals result bit 31.
- R8: With kind 3 and amount 0, the result is the operand shifted right by one with the incoming carry placed in bit 31, and the new carry is operand bit 0.
- R9: With the flag-update input high, the carry output is the new carry of R1 to R8. With it low, the carry output equals the carry input for every kind and amount. The result does not depend on the flag-update input.
- R10: Both outputs depend only on the present inputs, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to shift |
| kind_i | input | 2 | Shift kind: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right |
| amt_i | input | 5 | Immediate shift amount; 0 selects the special meaning of each kind |
| carry_i | input | 1 | Current carry flag |
| setflag_i | input | 1 | High to pass out the newly computed carry |
| result_o | output | 32 | Shifted result |
| carry_o | output | 1 | Carry to be written to the flag register |

## Verification
The zero-amount rotate is where two functions meet in one evaluation. It uses the incoming carry twice: once as the data bit that enters bit 31, and once as the carry output when flag update is disabled. Both uses are exercised by applying operands whose bit 0 differs from the carry input, with flag update both on and off. The result must carry the incoming flag in bit 31 in both cases. The carry output must switch between operand bit 0 and the held carry. A full sweep of all 128 kind-and-amount codes also repeats this clash for every right shift of amount zero. That sweep uses random operands and random flag inputs and compares each evaluation against a model built from 64-bit arithmetic in the bench.

// File: rtl/shift_pkg.sv
// Package: shared encodings for the immediate shifter.
// Assumes a 2-bit kind field whose code values are fixed by the decoder.
package shift_pkg;
    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shift_kind_e;
endpackage

// File: rtl/shift_left_unit.sv
// Left logical shift by an immediate amount.
// Assumes amount 0 means "no shift", which keeps the incoming carry.
module shift_left_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam logic [AMT_W:0] FULL = (AMT_W+1)'(WIDTH);

    logic [AMT_W:0]   exit_pos;
    logic [WIDTH-1:0] low_mask;

    // Shift, and pick the last bit pushed out at the top.
    always_comb begin
        exit_pos = FULL - {1'b0, amt_i};
        res_o    = opnd_i << amt_i;
        if (amt_i == '0) cout_o = carry_i;
        else             cout_o = opnd_i[exit_pos[AMT_W-1:0]];
    end

    // R1 guard: vacated low bits are zero.
    always_comb begin
        low_mask = (WIDTH'(1) << amt_i) - WIDTH'(1);
        a_r1_low_zero: assert ((res_o & low_mask) == '0)
            else $error("left shift left nonzero fill");
    end
endmodule

// File: rtl/shift_right_unit.sv
// Right shift by an immediate amount, logical or arithmetic by parameter.
// Assumes amount 0 encodes a shift by the full word width.
module shift_right_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH),
    parameter bit ARITH = 1'b0
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    logic             fill;
    logic [AMT_W-1:0] last_pos;
    logic [WIDTH-1:0] hi_mask;

    // Vacated bits take the sign in arithmetic mode, zero otherwise.
    always_comb fill = ARITH ? opnd_i[WIDTH-1] : 1'b0;

    // Shift; amount 0 drains the whole word.
    always_comb begin
        last_pos = amt_i - AMT_W'(1);
        if (amt_i == '0) begin
            res_o  = {WIDTH{fill}};
            cout_o = opnd_i[WIDTH-1];
        end else begin
            if (ARITH) res_o = $unsigned($signed(opnd_i) >>> amt_i);
            else       res_o = opnd_i >> amt_i;
            cout_o = opnd_i[last_pos];
        end
    end

    // R3/R5 guard: vacated top bits all equal the fill bit.
    always_comb begin
        hi_mask = ~({WIDTH{1'b1}} >> amt_i);
        a_r3_r5_top_fill: assert ((res_o & hi_mask) == (fill ? hi_mask : '0))
            else $error("right shift fill wrong");
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Rotate right by an immediate amount; amount 0 rotates one place through carry.
// Assumes the incoming carry is valid whenever amount is 0.
module shift_rotate_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam logic [AMT_W:0] FULL = (AMT_W+1)'(WIDTH);

    logic [AMT_W:0] back_amt;

    // Rotate, or extended rotate through carry when amount is 0.
    always_comb begin
        back_amt = FULL - {1'b0, amt_i};
        if (amt_i == '0) begin
            res_o  = {carry_i, opnd_i[WIDTH-1:1]};
            cout_o = opnd_i[0];
        end else begin
            res_o  = (opnd_i >> amt_i) | (opnd_i << back_amt);
            cout_o = res_o[WIDTH-1];
        end
    end

    // R7 guard: a plain rotate keeps the population count.
    always_comb begin
        if (amt_i != '0)
            a_r7_pop_kept: assert ($countones(res_o) == $countones(opnd_i))
                else $error("rotate lost bits");
    end

    // R8 guard: carry rotate swaps bit 0 out for the carry in.
    always_comb begin
        if (amt_i == '0)
            a_r8_rrx_pop: assert ($countones(res_o) + $countones(opnd_i[0])
                                  == $countones(opnd_i) + $countones(carry_i))
                else $error("rrx population mismatch");
    end
endmodule

// File: rtl/imm_barrel_shift.sv
// Top: immediate-amount shifter with carry out for a 32-bit datapath.
// Combinational; the flag register and ALU sit outside. Kind codes come from shift_pkg.
module imm_barrel_shift #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [1:0]       kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    input  logic             setflag_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    import shift_pkg::*;

    localparam int NRIGHT = 2;

    shift_kind_e      kind;
    logic [WIDTH-1:0] lsl_res, ror_res;
    logic             lsl_c, ror_c;
    logic [WIDTH-1:0] rsh_res [NRIGHT];
    logic             rsh_c   [NRIGHT];
    logic             new_c;

    // Decode the kind field.
    always_comb kind = shift_kind_e'(kind_i);

    shift_left_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_left (
        .opnd_i(opnd_i), .amt_i(amt_i), .carry_i(carry_i),
        .res_o(lsl_res), .cout_o(lsl_c)
    );

    // One right shifter per variant: index 0 logical, index 1 arithmetic.
    for (genvar g = 0; g < NRIGHT; g++) begin : g_right
        shift_right_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W), .ARITH(g == 1)) u_right (
            .opnd_i(opnd_i), .amt_i(amt_i),
            .res_o(rsh_res[g]), .cout_o(rsh_c[g])
        );
    end

    shift_rotate_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_rot (
        .opnd_i(opnd_i), .amt_i(amt_i), .carry_i(carry_i),
        .res_o(ror_res), .cout_o(ror_c)
    );

    // Select the unit output named by the kind field.
    always_comb begin
        unique case (kind)
            SHK_LSL: begin result_o = lsl_res;    new_c = lsl_c;    end
            SHK_LSR: begin result_o = rsh_res[0]; new_c = rsh_c[0]; end
            SHK_ASR: begin result_o = rsh_res[1]; new_c = rsh_c[1]; end
            default: begin result_o = ror_res;    new_c = ror_c;    end
        endcase
    end

    // Pass the new carry only when flags are being written.
    always_comb carry_o = setflag_i ? new_c : carry_i;

    // R2 guard: a zero left shift is a pure pass-through.
    always_comb begin
        if (kind == SHK_LSL && amt_i == '0)
            a_r2_lsl0_pass: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("zero left shift altered data");
    end

    // R4 guard: the full-width logical drain gives zero with the top bit as carry.
    always_comb begin
        if (kind == SHK_LSR && amt_i == '0 && setflag_i)
            a_r4_lsr32: assert (result_o == '0 && carry_o == opnd_i[WIDTH-1])
                else $error("logical drain wrong");
    end
endmodule

// File: tb/test_imm_barrel_shift.sv
// Directed bench for imm_barrel_shift with an independent 64-bit reference.
module test_imm_barrel_shift;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd;
    logic [1:0]  kind;
    logic [4:0]  amt;
    logic        cin, setf;
    logic [31:0] res;
    logic        cout;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    imm_barrel_shift i_imm_barrel_shift (
        .opnd_i(opnd), .kind_i(kind), .amt_i(amt), .carry_i(cin),
        .setflag_i(setf), .result_o(res), .carry_o(cout)
    );

    // Reference built on a 64-bit scratch word.
    function automatic logic [32:0] model(input logic [31:0] a, input logic [1:0] k,
                                          input logic [4:0] n, input logic c, input logic sf);
        logic [63:0] w;
        logic [31:0] r;
        logic        nc;
        int          sh;
        sh = (n == 0) ? 32 : int'(n);
        case (k)
            2'd0: begin
                w  = {32'd0, a} << n;
                r  = w[31:0];
                nc = (n == 0) ? c : w[32];
            end
            2'd1: begin
                w  = {a, 32'd0} >> sh;
                r  = w[63:32];
                nc = w[31];
            end
            2'd2: begin
                w  = {{32{a[31]}}, a} >> sh;
                r  = w[31:0];
                nc = a[sh-1];
            end
            default: begin
                if (n == 0) begin
                    r  = {c, a[31:1]};
                    nc = a[0];
                end else begin
                    w  = {a, a} >> n;
                    r  = w[31:0];
                    nc = r[31];
                end
            end
        endcase
        return {sf ? nc : c, r};
    endfunction

    task automatic apply(input logic [31:0] a, input logic [1:0] k,
                         input logic [4:0] n, input logic c, input logic sf);
        @(negedge clk);
        opnd = a; kind = k; amt = n; cin = c; setf = sf;
        #5;
    endtask

    task automatic chk(input string req, input logic [31:0] er, input logic ec);
        n_chk++;
        if (res !== er || cout !== ec) begin
            n_bad++;
            $display("FAIL %s: got res=%h c=%b, want res=%h c=%b (a=%h k=%0d n=%0d)",
                     req, res, cout, er, ec, opnd, kind, amt);
        end
    endtask

    task automatic run_one(input string req, input logic [31:0] a, input logic [1:0] k,
                           input logic [4:0] n, input logic c, input logic sf);
        logic [32:0] e;
        apply(a, k, n, c, sf);
        e = model(a, k, n, c, sf);
        chk(req, e[31:0], e[32]);
    endtask

    // R10: outputs with quiet inputs while reset is held.
    task automatic t_reset_state();
        apply(32'h0, 2'd0, 5'd0, 1'b0, 1'b0);
        chk("R10 reset", 32'h0, 1'b0);
    endtask

    task automatic t_left();
        apply(32'h8000_0001, 2'd0, 5'd1, 1'b0, 1'b1);
        chk("R1 lsl1", 32'h0000_0002, 1'b1);
        apply(32'h0000_0001, 2'd0, 5'd31, 1'b1, 1'b1);
        chk("R1 lsl31", 32'h8000_0000, 1'b0);
        apply(32'hDEAD_BEEF, 2'd0, 5'd0, 1'b1, 1'b1);
        chk("R2 lsl0", 32'hDEAD_BEEF, 1'b1);
    endtask

    task automatic t_right();
        apply(32'hF000_0010, 2'd1, 5'd5, 1'b0, 1'b1);
        chk("R3 lsr5", 32'h0780_0000, 1'b1);
        apply(32'h8000_0000, 2'd1, 5'd0, 1'b0, 1'b1);
        chk("R4 lsr32", 32'h0, 1'b1);
        apply(32'h8000_0004, 2'd2, 5'd3, 1'b0, 1'b1);
        chk("R5 asr3", 32'hF000_0000, 1'b1);
        apply(32'h8000_0000, 2'd2, 5'd0, 1'b0, 1'b1);
        chk("R6 asr32neg", 32'hFFFF_FFFF, 1'b1);
        apply(32'h7FFF_FFFF, 2'd2, 5'd0, 1'b1, 1'b1);
        chk("R6 asr32pos", 32'h0, 1'b0);
    endtask

    task automatic t_rotate();
        apply(32'h0000_0001, 2'd3, 5'd1, 1'b0, 1'b1);
        chk("R7 ror1", 32'h8000_0000, 1'b1);
        apply(32'h1234_5678, 2'd3, 5'd16, 1'b1, 1'b1);
        chk("R7 ror16", 32'h5678_1234, 1'b0);
        apply(32'h0000_0002, 2'd3, 5'd0, 1'b1, 1'b1);
        chk("R8 rrx", 32'h8000_0001, 1'b0);
    endtask

    // R9: flag hold meets the carry rotate in the same evaluation.
    task automatic t_flag_hold();
        apply(32'h0000_0003, 2'd3, 5'd0, 1'b0, 1'b0);
        chk("R9 rrx hold0", 32'h0000_0001, 1'b0);
        apply(32'h0000_0002, 2'd3, 5'd0, 1'b1, 1'b0);
        chk("R9 rrx hold1", 32'h8000_0001, 1'b1);
        apply(32'h8000_0000, 2'd1, 5'd0, 1'b0, 1'b0);
        chk("R9 lsr hold", 32'h0, 1'b0);
    endtask

    // R1-to-R9 sweep: every kind and amount code, random operand and flags.
    task automatic t_sweep();
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 32; n++) begin
                for (int r = 0; r < 3; r++) begin
                    run_one("R9 sweep", $urandom, 2'(k), 5'(n), 1'($urandom), 1'($urandom));
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        opnd = '0; kind = '0; amt = '0; cin = 1'b0; setf = 1'b0;
        t_reset_state();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_left();
        t_right();
        t_rotate();
        t_flag_hold();
        t_sweep();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule